// File: doc/BRIEF.md
# Programmable Watchdog Supervisor with Startup Delay

This block is a watchdog timer driven from one byte-wide control register. A 3-bit setting code in the low bits selects a pair of periods: a startup grace period and a timeout. Some codes turn the watchdog off instead. Software keeps the supervisor quiet by toggling a kick bit in the same register. If the timeout runs out with no kick, the block drives a reset pulse. Time is counted in ticks of a one-cycle strobe. The number of ticks per second is a parameter, so the table keeps its meaning at any tick rate.

Writing a setting code that differs from the stored one restarts the sequence. The block first waits out the grace period and ignores kicks during it. It then counts the timeout, and every kick reloads the count. Settings without a grace period do not count at all until the first kick edge. When a timeout expires, the reset pulse lasts a parameterised number of ticks. The sequence then starts again as though the current setting had just been written.

Top module: `wdog_supervisor`

## Requirements
- R1: After reset the control register reads 0x03 (watchdog off) and `rst_out` is low.
- R2: A write stores all eight bits and `rd_data` shows them from the next cycle on. Bits 7:4 have no other effect, and with no write the register holds its value.
- R3: Setting codes 0, 3 and 4 turn the watchdog off. `rst_out` stays low whatever ticks or kicks arrive.
- R4: The setting code sits in bits 2:0. Code 1 gives a 3 s grace period and a 3 s timeout, code 2 gives 60 s and 1 s, and code 7 gives 60 s and 10 s. Kicks during the grace period are ignored.
- R5: With no kick, `rst_out` rises on the clock edge that carries the (grace + timeout) × TICKS_PER_SEC-th tick after the setting write.
- R6: Codes 5 (1 s timeout) and 6 (10 s timeout) have no grace period. They stay idle until the first kick edge, and the timeout counts from that edge.
- R7: The kick bit is bit 3. Only a write that changes it from 0 to 1 is a kick, and a kick reloads the full timeout. Rewriting it as 1 while it is already 1 is not a kick.
- R8: `rst_out` stays high for PULSE_TICKS ticks. The block then restarts the current setting from its grace period, or from idle for codes with no grace period.
- R9: A write that changes bits 2:0 restarts the sequence under the new code at once, cancelling any pulse in progress. A write that keeps the same code does not restart it.
- R10: Without ticks, no period advances and `rst_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data: [2:0] setting code, [3] kick bit, [7:4] spare storage |
| tick | input | 1 | One-cycle time-base strobe |
| rd_data | output | 8 | Current control register contents |
| rst_out | output | 1 | Reset pulse raised on timeout expiry |

## Verification
On every cycle the assertions check the following:
- the off codes never coexist with an active pulse;
- the pulse begins only on a tick and ends only on a tick or a write;
- the register echoes each write and otherwise holds;
- the output is frozen when neither a tick nor a write is present.

Exact period lengths, the ignoring of kicks during the grace period, the held-high kick bit, and the restart after a pulse can only be seen in the bench scenarios. There a behavioural model is compared with the outputs every cycle, and direct checks pin down the edge on which the pulse rises and falls.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int LONGEST_UNITS = 60;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_DELAY,
        ST_ARMED,
        ST_RUN,
        ST_FIRE
    } wd_state_e;

    typedef struct packed {
        logic       enabled;
        logic [5:0] grace_s;
        logic [5:0] limit_s;
    } wd_setting_t;

    // Setting code to (grace, timeout) in seconds; undefined codes are off.
    function automatic wd_setting_t decode_setting(input logic [2:0] code);
        wd_setting_t s;
        s = '0;
        case (code)
            3'd1: s = '{enabled: 1'b1, grace_s: 6'd3,  limit_s: 6'd3};
            3'd2: s = '{enabled: 1'b1, grace_s: 6'd60, limit_s: 6'd1};
            3'd5: s = '{enabled: 1'b1, grace_s: 6'd0,  limit_s: 6'd1};
            3'd6: s = '{enabled: 1'b1, grace_s: 6'd0,  limit_s: 6'd10};
            3'd7: s = '{enabled: 1'b1, grace_s: 6'd60, limit_s: 6'd10};
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/wdog_regif.sv
module wdog_regif (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] ctrl,
    output logic       kick,
    output logic       restart
);
    typedef struct packed {
        logic [7:0] ctrl;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.ctrl = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ctrl <= 8'h03;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl    = r_q.ctrl;
    assign kick    = wr_en && wr_data[3] && !r_q.ctrl[3];
    assign restart = wr_en && (wr_data[2:0] != r_q.ctrl[2:0]);

endmodule

// File: rtl/wdog_seq.sv
module wdog_seq #(
    parameter int TICKS_PER_SEC = 1,
    parameter int PULSE_TICKS   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       kick,
    input  logic       restart,
    input  logic [2:0] code_new,
    input  logic [2:0] code_cur,
    output logic       fire
);
    import wdog_pkg::*;

    localparam int LONGEST = LONGEST_UNITS * TICKS_PER_SEC;
    localparam int CNT_MAX = (LONGEST > PULSE_TICKS) ? LONGEST : PULSE_TICKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        wd_state_e        st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic [CNT_W-1:0] scale(input logic [5:0] units);
        return CNT_W'(int'(units) * TICKS_PER_SEC);
    endfunction

    function automatic seq_t launch(input logic [2:0] code);
        wd_setting_t cfg;
        seq_t        s;
        cfg = decode_setting(code);
        s.st  = ST_OFF;
        s.cnt = '0;
        if (cfg.enabled) begin
            if (cfg.grace_s != 6'd0) begin
                s.st  = ST_DELAY;
                s.cnt = scale(cfg.grace_s);
            end else begin
                s.st  = ST_ARMED;
            end
        end
        return s;
    endfunction

    wd_setting_t cur_cfg;
    assign cur_cfg = decode_setting(code_cur);

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d = launch(code_new);
        end else begin
            case (s_q.st)
                ST_DELAY: if (tick) begin
                    if (s_q.cnt == CNT_W'(1)) begin
                        s_d.st  = ST_RUN;
                        s_d.cnt = scale(cur_cfg.limit_s);
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
                ST_ARMED: if (kick) begin
                    s_d.st  = ST_RUN;
                    s_d.cnt = scale(cur_cfg.limit_s);
                end
                ST_RUN: begin
                    if (kick) begin
                        s_d.cnt = scale(cur_cfg.limit_s);
                    end else if (tick) begin
                        if (s_q.cnt == CNT_W'(1)) begin
                            s_d.st  = ST_FIRE;
                            s_d.cnt = CNT_W'(PULSE_TICKS);
                        end else begin
                            s_d.cnt = s_q.cnt - CNT_W'(1);
                        end
                    end
                end
                ST_FIRE: if (tick) begin
                    if (s_q.cnt == CNT_W'(1)) begin
                        s_d = launch(code_cur);
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
                default: s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= ST_OFF;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fire = (s_q.st == ST_FIRE);

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
    parameter int TICKS_PER_SEC = 1,
    parameter int PULSE_TICKS   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       tick,
    output logic [7:0] rd_data,
    output logic       rst_out
);
    logic [7:0] ctrl;
    logic       kick;
    logic       restart;

    wdog_regif u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .kick    (kick),
        .restart (restart)
    );

    wdog_seq #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .PULSE_TICKS   (PULSE_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .kick     (kick),
        .restart  (restart),
        .code_new (wr_data[2:0]),
        .code_cur (ctrl[2:0]),
        .fire     (rst_out)
    );

    assign rd_data = ctrl;

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       tick,
    input logic [7:0] rd_data,
    input logic       rst_out
);
    p_off_codes_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2:0] == 3'd0 || rd_data[2:0] == 3'd3 || rd_data[2:0] == 3'd4) |-> !rst_out);

    p_pulse_starts_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $past(tick));

    p_pulse_ends_on_tick_or_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> ($past(tick) || $past(wr_en)));

    p_write_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (rd_data == $past(wr_data)));

    p_reg_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(rd_data));

    p_frozen_without_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(rst_out));

endmodule

bind wdog_supervisor wdog_supervisor_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .tick    (tick),
    .rd_data (rd_data),
    .rst_out (rst_out)
);

// File: tb/sim_wdog_supervisor.sv
`timescale 1ns/1ps
module sim_wdog_supervisor;
    localparam int TPS   = 2;
    localparam int PULSE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick = 1'b0;
    logic [7:0] rd_data;
    logic       rst_out;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    wdog_supervisor #(.TICKS_PER_SEC(TPS), .PULSE_TICKS(PULSE)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .rd_data(rd_data), .rst_out(rst_out)
    );

    // Behavioural reference: modes 0 off, 1 grace, 2 idle-armed, 3 counting, 4 pulsing
    int         m_mode = 0;
    int         m_left = 0;
    logic [7:0] m_reg  = 8'h03;
    bit         m_kick, m_new;

    function automatic int grace_ticks(input int code);
        if (code == 1) return 3 * TPS;
        if (code == 2 || code == 7) return 60 * TPS;
        return 0;
    endfunction

    function automatic int limit_ticks(input int code);
        if (code == 1) return 3 * TPS;
        if (code == 6 || code == 7) return 10 * TPS;
        if (code == 2 || code == 5) return TPS;
        return 0;
    endfunction

    function automatic bit code_on(input int code);
        return code == 1 || code == 2 || code >= 5;
    endfunction

    task automatic m_begin(input int code);
        if (!code_on(code)) begin m_mode = 0; m_left = 0; end
        else if (grace_ticks(code) > 0) begin m_mode = 1; m_left = grace_ticks(code); end
        else begin m_mode = 2; m_left = 0; end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_reg = 8'h03; m_mode = 0; m_left = 0;
        end else begin
            m_kick = 0; m_new = 0;
            if (wr_en) begin
                m_kick = wr_data[3] && !m_reg[3];
                m_new  = wr_data[2:0] != m_reg[2:0];
                m_reg  = wr_data;
            end
            if (m_new) m_begin(int'(m_reg[2:0]));
            else if (m_mode == 1 && tick) begin
                m_left--;
                if (m_left == 0) begin m_mode = 3; m_left = limit_ticks(int'(m_reg[2:0])); end
            end else if (m_mode == 2 && m_kick) begin
                m_mode = 3; m_left = limit_ticks(int'(m_reg[2:0]));
            end else if (m_mode == 3) begin
                if (m_kick) m_left = limit_ticks(int'(m_reg[2:0]));
                else if (tick) begin
                    m_left--;
                    if (m_left == 0) begin m_mode = 4; m_left = PULSE; end
                end
            end else if (m_mode == 4 && tick) begin
                m_left--;
                if (m_left == 0) m_begin(int'(m_reg[2:0]));
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic compare_model();
        check(cur_req, int'(rd_data), int'(m_reg));
        check(cur_req, int'(rst_out), (m_mode == 4) ? 1 : 0);
    endtask

    // Starts and ends at a falling edge; results of the rising edge are visible on return.
    task automatic cyc(input bit we, input logic [7:0] d, input bit tk);
        wr_en = we; wr_data = d; tick = tk;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        compare_model();
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            cyc(0, 8'h00, 1);
            for (int g = 0; g < gap; g++) cyc(0, 8'h00, 0);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles == 20000) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        check("R1", int'(rd_data), 8'h03);
        check("R1", int'(rst_out), 0);
        cyc(0, 8'h00, 0);

        // R2 / R3: off codes, spare bits
        cur_req = "R2";
        cyc(1, 8'hA3, 0);
        check("R2", int'(rd_data), 8'hA3);
        cur_req = "R3";
        ticks(60, 0);
        cyc(1, 8'h0B, 1); cyc(1, 8'h03, 1);
        check("R3", int'(rst_out), 0);
        cyc(1, 8'h00, 0);
        ticks(150, 0);
        check("R3", int'(rst_out), 0);
        cyc(1, 8'h54, 0);
        ticks(150, 0);
        check("R3", int'(rst_out), 0);

        // R4 / R5: code 1, kicks during grace ignored, fires after 12 ticks
        cur_req = "R4";
        cyc(1, 8'h01, 0);
        cyc(1, 8'h09, 1);
        cyc(1, 8'h01, 1);
        cur_req = "R5";
        ticks(9, 0);
        check("R5", int'(rst_out), 0);
        ticks(1, 0);
        check("R5", int'(rst_out), 1);
        // R8 pulse width and restart
        cur_req = "R8";
        ticks(2, 0);
        check("R8", int'(rst_out), 1);
        ticks(1, 0);
        check("R8", int'(rst_out), 0);
        ticks(11, 0);
        check("R8", int'(rst_out), 0);
        ticks(1, 0);
        check("R8", int'(rst_out), 1);
        // R9: new code cancels pulse
        cur_req = "R9";
        cyc(1, 8'h05, 0);
        check("R9", int'(rst_out), 0);

        // R6: code 5 idle until kick edge
        cur_req = "R6";
        ticks(40, 0);
        check("R6", int'(rst_out), 0);
        cyc(1, 8'h0D, 0);
        cyc(1, 8'h05, 0);
        ticks(1, 0);
        check("R6", int'(rst_out), 0);
        ticks(1, 0);
        check("R6", int'(rst_out), 1);
        ticks(3, 0);
        ticks(20, 0);
        check("R6", int'(rst_out), 0);

        // R7: code 6, kicks reload, held-high bit is not a kick
        cur_req = "R7";
        cyc(1, 8'h06, 0);
        cyc(1, 8'h0E, 0);
        ticks(19, 0);
        check("R7", int'(rst_out), 0);
        cyc(1, 8'h06, 0);
        cyc(1, 8'h0E, 0);
        ticks(19, 0);
        check("R7", int'(rst_out), 0);
        cyc(1, 8'h0E, 1);
        check("R7", int'(rst_out), 1);
        cyc(1, 8'h06, 0);
        ticks(3, 0);

        // R9: same-code write keeps the running grace period
        cur_req = "R9";
        cyc(1, 8'h02, 0);
        ticks(100, 0);
        cyc(1, 8'hF2, 0);
        check("R2", int'(rd_data), 8'hF2);
        ticks(21, 0);
        check("R9", int'(rst_out), 0);
        ticks(1, 0);
        check("R9", int'(rst_out), 1);

        // R10: no ticks, no progress (code 7)
        cur_req = "R10";
        cyc(1, 8'h07, 0);
        ticks(130, 0);
        for (int i = 0; i < 300; i++) cyc(0, 8'h00, 0);
        check("R10", int'(rst_out), 0);
        ticks(9, 0);
        check("R10", int'(rst_out), 0);
        ticks(1, 0);
        check("R10", int'(rst_out), 1);

        // Sparse ticks with mixed writes
        cur_req = "R4";
        cyc(1, 8'h01, 0);
        ticks(30, 2);
        cyc(1, 8'h09, 0);
        ticks(5, 1);
        cur_req = "R3";
        cyc(1, 8'h00, 0);
        ticks(20, 1);
        check("R3", int'(rst_out), 0);
        cyc(1, 8'h03, 0);
        cyc(0, 8'h00, 0);

        finish_run();
    end
endmodule